// File: doc/BRIEF.md
# Key-Gated Ring-Counter Switch Configurator

This block configures the multiplexer switches of a small obfuscated FIR datapath. A serial configuration key enters one bit per clock while `key_valid` is high. The key has two parts. The first part is an initialization key. A sparsely encoded state machine checks it bit by bit against a masked reference. Only a fully matching initialization key enables the reconfigurator. The reconfigurator then takes the configure data that follows. If any initialization bit is wrong, the machine falls into a trap state. It stays there until reset, and no later key traffic has any effect.

The configure data sets the starting one-hot position of a ring counter for each switch. Each ring counter drives the select of a 4:1 multiplexer. The multiplexer picks which element of a four-deep sample window feeds a fixed-weight tap. Once the block is configured, every accepted sample rotates each ring counter by one position, so the tap ordering changes from sample to sample. Before configuration completes, every select sits at a default. The datapath then computes a wrong variant, which is the weighted sum of the newest sample alone.

Top module: `swcfg_switch_reconf`

## Requirements
- R1: After reset, `configured` is 0, `result_valid` is 0, `result` is 0 and every field of `sw_sel` is 0.
- R2: The first INIT_LEN (16) accepted key bits are the initialization key, sent most significant bit first and compared against INIT_KEY (default 16'hA5C3). A bit counts as accepted only in a cycle where `key_valid` is 1.
- R3: Any wrong initialization bit disables the reconfigurator until the next reset. All further key bits, including configure data, are ignored, and `configured` stays 0.
- R4: After a correct initialization key, the next CFG_LEN (8) accepted bits are configure data, sent most significant bit first. Bits [2j+1:2j] of the assembled byte give the starting select of switch j.
- R5: `configured` rises in the cycle after the last configure-data bit is accepted, and stays high until reset.
- R6: While `configured` is 0, every switch select is 0.
- R7: `sw_sel` bits [2j+1:2j] hold the current binary select (0..3) of switch j.
- R8: For each accepted sample, the registered `result` equals the sum over j of (2j+1)·w[sel_j]. Here w[0] is `sample_in` and w[k] is the k-th previously accepted sample, which is zero after reset. `result_valid` is high exactly in the cycle after `sample_valid`.
- R9: Once configured, each accepted sample advances every switch select by one, modulo 4, after the sample has used the old select. Without a sample, the selects hold.
- R10: Key bits received after configuration are ignored: `sw_sel` and `configured` do not change.
- R11: A sample accepted in the same cycle as the last configure-data bit uses the default selects. The ring counters then start at the loaded positions, not advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Key bit strobe |
| key_bit | input | 1 | Serial key bit |
| sample_valid | input | 1 | Sample strobe |
| sample_in | input | 8 | Signed input sample |
| result | output | 16 | Signed filter output |
| result_valid | output | 1 | Result strobe |
| configured | output | 1 | Configuration complete |
| sw_sel | output | 8 | Packed switch selects, 2 bits per switch |

## Verification
The last configure-data bit and a datapath sample can arrive in the same clock edge. At that edge the ring counters are loaded, and the sample is filtered with the selects in force before the load. The bench provokes this by raising `sample_valid` together with the final key bit. It then checks three things: the result equals the default-select sum, `sw_sel` shows the loaded positions without rotation, and the next sample uses those loaded positions before the first rotation.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

    typedef enum logic [2:0] {
        KS_CHECK = 3'b101,
        KS_LOAD  = 3'b011,
        KS_READY = 3'b110,
        KS_TRAP  = 3'b000
    } key_state_e;

    typedef struct packed {
        logic valid;
        logic data;
    } key_beat_t;

    function automatic int unsigned tap_weight(input int unsigned idx);
        return 2 * idx + 1;
    endfunction

endpackage

// File: rtl/swcfg_keyseq.sv
module swcfg_keyseq #(
    parameter int unsigned INIT_LEN = 16,
    parameter int unsigned CFG_LEN  = 8,
    parameter logic [INIT_LEN-1:0] INIT_KEY = 16'hA5C3,
    parameter logic [INIT_LEN-1:0] KEY_MASK = 16'h3C96
) (
    input  logic                  clk,
    input  logic                  rst,
    input  swcfg_pkg::key_beat_t  beat,
    output logic                  load_pulse,
    output logic [CFG_LEN-1:0]    cfg_word,
    output logic                  ready,
    output logic                  trapped
);
    import swcfg_pkg::*;

    localparam int unsigned MAXLEN = (INIT_LEN > CFG_LEN) ? INIT_LEN : CFG_LEN;
    localparam int unsigned CNT_W  = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] LAST_INIT = CNT_W'(INIT_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_CFG  = CNT_W'(CFG_LEN - 1);
    localparam logic [INIT_LEN-1:0] HIDDEN = INIT_KEY ^ KEY_MASK;

    key_state_e            state;
    logic [CNT_W-1:0]      cnt;
    logic [INIT_LEN-1:0]   ref_pat;
    logic [INIT_LEN-1:0]   mask_pat;
    logic [CFG_LEN-2:0]    shreg;
    logic                  bit_ok;

    assign bit_ok     = ((beat.data ^ mask_pat[INIT_LEN-1]) == ref_pat[INIT_LEN-1]);
    assign cfg_word   = {shreg, beat.data};
    assign load_pulse = (state == KS_LOAD) && beat.valid && (cnt == LAST_CFG);
    assign ready      = (state == KS_READY);
    assign trapped    = (state == KS_TRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= KS_CHECK;
            cnt      <= '0;
            ref_pat  <= HIDDEN;
            mask_pat <= KEY_MASK;
            shreg    <= '0;
        end else begin
            case (state)
                KS_CHECK: begin
                    if (beat.valid) begin
                        ref_pat  <= {ref_pat[INIT_LEN-2:0], 1'b0};
                        mask_pat <= {mask_pat[INIT_LEN-2:0], 1'b0};
                        if (!bit_ok) begin
                            state <= KS_TRAP;
                        end else if (cnt == LAST_INIT) begin
                            state <= KS_LOAD;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                KS_LOAD: begin
                    if (beat.valid) begin
                        shreg <= cfg_word[CFG_LEN-2:0];
                        if (cnt == LAST_CFG) begin
                            state <= KS_READY;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                KS_READY: state <= KS_READY;
                KS_TRAP:  state <= KS_TRAP;
                default:  state <= KS_TRAP;
            endcase
        end
    end

endmodule

// File: rtl/swcfg_ring.sv
module swcfg_ring #(
    parameter int unsigned POS = 4,
    localparam int unsigned IDX_W = $clog2(POS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] init_idx,
    input  logic             advance,
    input  logic             active,
    output logic [IDX_W-1:0] sel_idx
);
    logic [POS-1:0]   ring;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring <= POS'(1);
        end else if (load) begin
            ring <= POS'(1) << init_idx;
        end else if (advance) begin
            ring <= {ring[POS-2:0], ring[POS-1]};
        end
    end

    always_comb begin
        idx = '0;
        for (int p = 0; p < POS; p++) begin
            if (ring[p]) idx = IDX_W'(p);
        end
    end

    assign sel_idx = active ? idx : '0;

endmodule

// File: rtl/swcfg_datapath.sv
module swcfg_datapath #(
    parameter int unsigned N_SW = 4,
    parameter int unsigned POS  = 4,
    parameter int unsigned DW   = 8,
    parameter int unsigned OW   = 16,
    localparam int unsigned IDX_W = $clog2(POS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_valid,
    input  logic signed [DW-1:0]     sample_in,
    input  logic [N_SW*IDX_W-1:0]    sel_flat,
    output logic signed [OW-1:0]     result,
    output logic                     result_valid
);
    logic signed [DW-1:0] hist [POS-1];
    logic signed [DW-1:0] win  [POS];
    logic signed [OW-1:0] acc;

    always_comb begin
        win[0] = sample_in;
        for (int k = 1; k < POS; k++) win[k] = hist[k-1];
    end

    always_comb begin
        logic signed [OW-1:0] wgt;
        logic signed [OW-1:0] tap;
        logic [IDX_W-1:0]     s;
        acc = '0;
        for (int j = 0; j < N_SW; j++) begin
            s   = sel_flat[j*IDX_W +: IDX_W];
            wgt = OW'(swcfg_pkg::tap_weight(j));
            tap = OW'(win[s]);
            acc = acc + wgt * tap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < POS - 1; k++) hist[k] <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= sample_valid;
            if (sample_valid) begin
                hist[0] <= sample_in;
                for (int k = 1; k < POS - 1; k++) hist[k] <= hist[k-1];
                result <= acc;
            end
        end
    end

endmodule

// File: rtl/swcfg_switch_reconf.sv
module swcfg_switch_reconf #(
    parameter int unsigned INIT_LEN = 16,
    parameter int unsigned CFG_LEN  = 8,
    parameter int unsigned SEL_POS  = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned OUT_W    = 16,
    parameter logic [INIT_LEN-1:0] INIT_KEY = 16'hA5C3,
    parameter logic [INIT_LEN-1:0] KEY_MASK = 16'h3C96,
    localparam int unsigned IDX_W = $clog2(SEL_POS),
    localparam int unsigned N_SW  = CFG_LEN / IDX_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    key_valid,
    input  logic                    key_bit,
    input  logic                    sample_valid,
    input  logic [DATA_W-1:0]       sample_in,
    output logic [OUT_W-1:0]        result,
    output logic                    result_valid,
    output logic                    configured,
    output logic [N_SW*IDX_W-1:0]   sw_sel
);
    swcfg_pkg::key_beat_t  beat;
    logic                  load_pulse;
    logic [CFG_LEN-1:0]    cfg_word;
    logic                  ready;
    logic                  trap_w;
    logic signed [OUT_W-1:0] res_s;

    assign beat.valid = key_valid;
    assign beat.data  = key_bit;

    swcfg_keyseq #(
        .INIT_LEN(INIT_LEN), .CFG_LEN(CFG_LEN),
        .INIT_KEY(INIT_KEY), .KEY_MASK(KEY_MASK)
    ) i_keyseq (
        .clk(clk), .rst(rst), .beat(beat),
        .load_pulse(load_pulse), .cfg_word(cfg_word),
        .ready(ready), .trapped(trap_w)
    );

    for (genvar j = 0; j < N_SW; j++) begin : g_sw
        swcfg_ring #(.POS(SEL_POS)) i_ring (
            .clk(clk), .rst(rst),
            .load(load_pulse),
            .init_idx(cfg_word[j*IDX_W +: IDX_W]),
            .advance(ready & sample_valid),
            .active(ready),
            .sel_idx(sw_sel[j*IDX_W +: IDX_W])
        );
    end

    swcfg_datapath #(
        .N_SW(N_SW), .POS(SEL_POS), .DW(DATA_W), .OW(OUT_W)
    ) i_dp (
        .clk(clk), .rst(rst),
        .sample_valid(sample_valid),
        .sample_in($signed(sample_in)),
        .sel_flat(sw_sel),
        .result(res_s),
        .result_valid(result_valid)
    );

    assign result     = res_s;
    assign configured = ready;

endmodule

// File: rtl/swcfg_checker.sv
module swcfg_checker #(
    parameter int unsigned SEL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             key_valid,
    input logic             sample_valid,
    input logic             result_valid,
    input logic             configured,
    input logic             trapped,
    input logic [SEL_W-1:0] sw_sel
);
    p_default_sel_r6: assert property (@(posedge clk) disable iff (rst)
        !configured |-> (sw_sel == '0));

    p_sticky_cfg_r5: assert property (@(posedge clk) disable iff (rst)
        configured |=> configured);

    p_rise_after_key_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(configured) |-> $past(key_valid));

    p_trap_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        trapped |-> !configured);

    p_trap_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        trapped |=> trapped);

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> result_valid);

    p_valid_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> !result_valid);

    p_hold_sel_r9: assert property (@(posedge clk) disable iff (rst)
        (configured && !sample_valid) |=> $stable(sw_sel));

endmodule

bind swcfg_switch_reconf swcfg_checker #(.SEL_W(N_SW*IDX_W)) i_chk (
    .clk(clk), .rst(rst), .key_valid(key_valid),
    .sample_valid(sample_valid), .result_valid(result_valid),
    .configured(configured), .trapped(trap_w), .sw_sel(sw_sel)
);

// File: tb/test_swcfg_switch_reconf.sv
module test_swcfg_switch_reconf;
    localparam logic [15:0] KEY = 16'hA5C3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_valid = 1'b0;
    logic key_bit = 1'b0;
    logic sample_valid = 1'b0;
    logic [7:0] sample_in = '0;
    logic [15:0] result;
    logic result_valid;
    logic configured;
    logic [7:0] sw_sel;

    int n_checks = 0;
    int n_fail = 0;
    int hist [3];
    int pos [4];
    bit cfgd;

    always #10 clk = ~clk;

    swcfg_switch_reconf i_swcfg_switch_reconf (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_bit(key_bit),
        .sample_valid(sample_valid), .sample_in(sample_in),
        .result(result), .result_valid(result_valid),
        .configured(configured), .sw_sel(sw_sel)
    );

    // cfg byte, then samples s0..s3 (R4, R8, R9)
    localparam logic [39:0] VECS [5] = '{
        40'hE4_05_FD_11_80,
        40'h1B_7F_01_02_03,
        40'h00_10_20_F0_E0,
        40'hFF_09_F7_33_01,
        40'h9C_81_7F_00_44
    };

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        key_valid = 1'b0;
        sample_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 3; k++) hist[k] = 0;
        for (int j = 0; j < 4; j++) pos[j] = 0;
        cfgd = 1'b0;
    endtask

    task automatic push_bits(input logic [31:0] v, input int n, input int gap);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            key_valid = 1'b1;
            key_bit = v[i];
            if (gap != 0) begin
                @(negedge clk);
                key_valid = 1'b0;
                @(negedge clk);
            end
        end
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    function automatic int expect_sum(input int x);
        int w [4];
        int s;
        w[0] = x;
        for (int k = 1; k < 4; k++) w[k] = hist[k-1];
        s = 0;
        for (int j = 0; j < 4; j++) s += (2 * j + 1) * w[cfgd ? pos[j] : 0];
        return s;
    endfunction

    function automatic int packed_sel();
        int v = 0;
        for (int j = 0; j < 4; j++) v |= (cfgd ? pos[j] : 0) << (2 * j);
        return v;
    endfunction

    task automatic model_advance(input int x);
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = x;
        if (cfgd) for (int j = 0; j < 4; j++) pos[j] = (pos[j] + 1) % 4;
    endtask

    task automatic do_sample(input logic signed [7:0] x, input string req);
        int e;
        e = expect_sum(int'(x));
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in = x;
        @(negedge clk);
        sample_valid = 1'b0;
        check({req, " result"}, int'($signed(result)), e);
        check({req, " result_valid"}, int'(result_valid), 1);
        model_advance(int'(x));
        check("R9 sel after sample", int'(sw_sel), packed_sel());
    endtask

    task automatic set_cfg(input logic [7:0] c);
        cfgd = 1'b1;
        for (int j = 0; j < 4; j++) pos[j] = int'(c[2*j +: 2]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 configured", int'(configured), 0);
        check("R1 result_valid", int'(result_valid), 0);
        check("R1 result", int'(result), 0);
        check("R1 sw_sel", int'(sw_sel), 0);

        // R6: default selects before configuration
        do_sample(8'sd5, "R6 default");
        do_sample(-8'sd3, "R6 default neg");

        // Table walk: correct key, cfg, samples (R2 R4 R5 R7 R8 R9)
        for (int t = 0; t < 5; t++) begin
            do_reset();
            push_bits({16'h0, KEY}, 16, 0);
            check("R2 not yet configured", int'(configured), 0);
            push_bits({24'h0, VECS[t][39:32]}, 8, 0);
            check("R5 configured", int'(configured), 1);
            set_cfg(VECS[t][39:32]);
            check("R7 sw_sel loaded", int'(sw_sel), packed_sel());
            for (int s = 3; s >= 0; s--) do_sample(VECS[t][8*s +: 8], "R8 table");
        end

        // R3: wrong initialization key traps; cfg data ignored
        do_reset();
        push_bits({16'h0, KEY ^ 16'h0100}, 16, 0);
        push_bits(32'hE4, 8, 0);
        check("R3 configured", int'(configured), 0);
        check("R3 sw_sel", int'(sw_sel), 0);
        push_bits({16'h0, KEY}, 16, 0);
        push_bits(32'h1B, 8, 0);
        check("R3 retry ignored", int'(configured), 0);
        do_sample(8'sd2, "R3 default datapath");

        // R2 with gaps, R5 timing, R10 late key bits ignored
        do_reset();
        push_bits({16'h0, KEY}, 16, 1);
        push_bits(32'h4E >> 1, 7, 1);
        check("R5 not early", int'(configured), 0);
        push_bits(32'h4E, 1, 0);
        check("R5 rise", int'(configured), 1);
        set_cfg(8'h4E);
        check("R4 gap cfg", int'(sw_sel), packed_sel());
        push_bits(32'h00B1, 16, 0);
        check("R10 sw_sel held", int'(sw_sel), packed_sel());
        check("R10 configured held", int'(configured), 1);
        do_sample(8'sd7, "R10 datapath");

        // R11: last cfg bit and sample in the same cycle
        do_reset();
        push_bits({16'h0, KEY}, 16, 0);
        push_bits(32'hD2 >> 1, 7, 0);
        @(negedge clk);
        key_valid = 1'b1;
        key_bit = 1'b0;
        sample_valid = 1'b1;
        sample_in = 8'sd6;
        @(negedge clk);
        key_valid = 1'b0;
        sample_valid = 1'b0;
        check("R11 default result", int'($signed(result)), 96);
        check("R11 configured", int'(configured), 1);
        model_advance(6);
        set_cfg(8'hD2);
        check("R11 not advanced", int'(sw_sel), packed_sel());
        do_sample(8'sd4, "R11 first configured");
        do_sample(-8'sd9, "R11 second");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule